// File: doc/BRIEF.md
# Polled I/O Port Controller

This block is the device side of a byte-wide I/O port that a host services by polling. The host reaches four registers over a small register bus with an address, a read strobe, a write strobe and data buses. It loads an outgoing byte, then writes a command word that carries a ready flag and a direction flag. The controller raises a busy flag and performs the transfer on a simple valid/done device interface. It then lowers the ready flag and the busy flag, in that order, and reports success or a device fault in an error flag.

Incoming device bytes go into an eight-entry queue in front of the input register. Bursts are held there until the host reads them, and a status flag says whether at least one byte is waiting. The upper bits of the command word are mode bits, such as duplex, parity checking and line speed. They are stored and driven onto an output port for the surrounding logic. The controller itself does not act on them.

Top module: `polled_port_ctrl`

## Requirements
- R1: After reset, status, command word and mode output are zero, `dev_tx_valid` is low, `dev_rx_ready` is high and a read of address 0 returns 0.
- R2: Address map: 0 reads the input queue head (0 when empty), 1 is the output byte (read/write), 2 is status (bit0 busy, bit1 byte available, bit2 error, bit3 queue full, other bits 0), 3 is the command word (bit0 command-ready, bit1 write, bits 7:2 mode). Writes to 0 and 2 have no effect.
- R3: A command-ready bit that is set while the controller is idle makes busy read 1 on the next clock edge.
- R4: For a write command (bit1 = 1), `dev_tx_valid` rises one edge after busy with `dev_tx_data` equal to the output byte. Both are held until the edge where `dev_tx_done` is high.
- R5: On the edge that completes a command, command-ready clears and the error bit takes its new value. Busy clears on the following edge, so command-ready is never set when busy falls.
- R6: A completion with `dev_err` high sets the error bit. The error bit stays set, with command-ready and busy still cleared as in R5, until a later command completes without fault, which clears it.
- R7: Host writes to the output byte or the command word while busy reads 1 leave both registers and the mode output unchanged.
- R8: A command with bit1 = 0 makes no device transfer. It clears command-ready and error one edge after busy rises, and busy two edges after it rises.
- R9: The input queue holds 8 bytes. `dev_rx_ready` is high exactly when the queue is not full, and a byte is stored on an edge where both `dev_rx_valid` and `dev_rx_ready` are high.
- R10: A read strobe at address 0 removes the head byte, so bytes come out in arrival order. A read of an empty queue returns 0 and changes nothing. The byte-available bit equals queue-not-empty.
- R11: `mode_out` always equals the mode bits of the command word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register address |
| reg_rd | input | 1 | Read strobe (pops the queue at address 0) |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the current address |
| dev_tx_valid | output | 1 | Outgoing byte offered to the device |
| dev_tx_data | output | 8 | Outgoing byte |
| dev_tx_done | input | 1 | Device finished the outgoing transfer |
| dev_err | input | 1 | Device reports a fault with `dev_tx_done` |
| dev_rx_valid | input | 1 | Device offers an incoming byte |
| dev_rx_data | input | 8 | Incoming byte |
| dev_rx_ready | output | 1 | Queue can take an incoming byte |
| mode_out | output | 6 | Stored mode bits |

## Verification
The bench targets the order in which the flags clear at the end of a command. A design that dropped busy together with command-ready, or before it, would let a polling host start a new command while the old one is still finishing. It writes the output byte and the command word in the cycles where the transfer is being loaded and held. A design that did not honour busy would send, or later show, the wrong byte. It also fills the queue past eight entries, reads it while empty, and pushes and pops in the same cycle. A faulty design would lose or duplicate bytes, report availability wrongly, or give a nonzero byte on an empty read. Error persistence is checked across faulted, no-transfer and clean commands, so an error bit that clears too early or never clears shows up.

// File: rtl/polled_port_ctrl.sv
module polled_port_ctrl #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              dev_tx_valid,
  output logic [DATA_W-1:0] dev_tx_data,
  input  logic              dev_tx_done,
  input  logic              dev_err,
  input  logic              dev_rx_valid,
  input  logic [DATA_W-1:0] dev_rx_data,
  output logic              dev_rx_ready,
  output logic [DATA_W-3:0] mode_out
);

  localparam int MODE_W = DATA_W - 2;
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_ACCEPT, ST_XFER, ST_CLEAR} state_t;

  state_t            st;
  logic              busy_q, err_q, cmd_ready, wbit;
  logic [MODE_W-1:0] mode_q;
  logic [DATA_W-1:0] data_out;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  fifo_cnt;
  logic              empty, full, push, pop;

  assign empty        = (fifo_cnt == '0);
  assign full         = (fifo_cnt == CNT_W'(DEPTH));
  assign dev_rx_ready = !full;
  assign push         = dev_rx_valid && !full;
  assign pop          = reg_rd && (reg_addr == 2'd0) && !empty;
  assign mode_out     = mode_q;

  wire host_wr_out = reg_wr && (reg_addr == 2'd1) && !busy_q;
  wire host_wr_cmd = reg_wr && (reg_addr == 2'd3) && !busy_q;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = empty ? '0 : mem[rd_ptr];
      2'd1:    reg_rdata = data_out;
      2'd2:    reg_rdata = DATA_W'({full, err_q, !empty, busy_q});
      default: reg_rdata = {mode_q, wbit, cmd_ready};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) data_out <= '0;
    else if (host_wr_out) data_out <= reg_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= ST_IDLE;
      busy_q       <= 1'b0;
      err_q        <= 1'b0;
      cmd_ready    <= 1'b0;
      wbit         <= 1'b0;
      mode_q       <= '0;
      dev_tx_valid <= 1'b0;
      dev_tx_data  <= '0;
    end else begin
      if (host_wr_cmd) begin
        cmd_ready <= reg_wdata[0];
        wbit      <= reg_wdata[1];
        mode_q    <= reg_wdata[DATA_W-1:2];
      end
      case (st)
        ST_IDLE: if (cmd_ready) begin
          busy_q <= 1'b1;
          st     <= ST_ACCEPT;
        end
        ST_ACCEPT: if (wbit) begin
          dev_tx_valid <= 1'b1;
          dev_tx_data  <= data_out;
          st           <= ST_XFER;
        end else begin
          cmd_ready <= 1'b0;
          err_q     <= 1'b0;
          st        <= ST_CLEAR;
        end
        ST_XFER: if (dev_tx_done) begin
          dev_tx_valid <= 1'b0;
          cmd_ready    <= 1'b0;
          err_q        <= dev_err;
          st           <= ST_CLEAR;
        end
        default: begin
          busy_q <= 1'b0;
          st     <= ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= dev_rx_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      fifo_cnt <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   fifo_cnt <= fifo_cnt + 1'b1;
        2'b01:   fifo_cnt <= fifo_cnt - 1'b1;
        default: fifo_cnt <= fifo_cnt;
      endcase
    end
  end

  a_r3_busy_follows_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && cmd_ready) |=> busy_q);

  a_r4_tx_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    dev_tx_valid |-> busy_q);

  a_r4_tx_held: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_tx_valid && !dev_tx_done) |=> (dev_tx_valid && $stable(dev_tx_data)));

  a_r5_ready_clears_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> (!cmd_ready && $past(!cmd_ready)));

  a_r7_out_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && reg_wr && reg_addr == 2'd1) |=> $stable(data_out));

  a_r7_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && reg_wr && reg_addr == 2'd3) |=> $stable(mode_q));

  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CNT_W'(DEPTH));

  a_r9_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full);

endmodule

// File: tb/tb_polled_port_ctrl.sv
`timescale 1ns/1ps
module tb_polled_port_ctrl;
  logic       clk = 0, rst_n = 0;
  logic [1:0] reg_addr = 0;
  logic       reg_rd = 0, reg_wr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic       dev_tx_valid, dev_tx_done = 0, dev_err = 0;
  logic [7:0] dev_tx_data;
  logic       dev_rx_valid = 0, dev_rx_ready;
  logic [7:0] dev_rx_data = 0;
  logic [5:0] mode_out;

  int checks = 0, errors = 0;
  logic [7:0] q[$];
  logic [5:0] exp_mode = 0;
  logic       exp_err = 0;

  always #5 clk = ~clk;

  polled_port_ctrl dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  function automatic logic [7:0] status_exp(input logic busy);
    return {4'b0, (q.size() == 8), exp_err, (q.size() != 0), busy};
  endfunction

  task automatic do_cmd(input logic [7:0] d, input logic [5:0] m, input logic w,
                        input logic e, input int lat);
    logic [7:0] v;
    wr(2'd1, d);
    wr(2'd3, {m, w, 1'b1});
    exp_mode = m;
    peek(2'd3, v); chk("R3 ready set, not yet busy", v, {m, w, 1'b1});
    peek(2'd2, v); chk("R3 busy low before edge", v[0], 0);
    @(negedge clk);
    peek(2'd2, v); chk("R3 busy one edge after ready", v[0], 1);
    chk("R4 no tx yet", dev_tx_valid, 0);
    if (w) begin
      wr(2'd1, ~d);
      chk("R4 tx valid", dev_tx_valid, 1);
      chk("R4 R7 tx byte", dev_tx_data, d);
      for (int i = 0; i < lat; i++) begin
        wr(2'd3, 8'hFC);
        chk("R4 tx held", {dev_tx_valid, dev_tx_data}, {1'b1, d});
        chk("R7 mode locked", mode_out, exp_mode);
      end
      dev_tx_done = 1; dev_err = e;
      @(negedge clk); dev_tx_done = 0; dev_err = 0;
      exp_err = e;
      chk("R4 tx dropped", dev_tx_valid, 0);
    end else begin
      @(negedge clk);
      exp_err = 0;
      chk("R8 no transfer", dev_tx_valid, 0);
    end
    peek(2'd3, v); chk("R5 ready cleared", v[0], 0);
    peek(2'd2, v); chk("R5 R6 busy still set, error updated", v, status_exp(1));
    @(negedge clk);
    peek(2'd2, v); chk("R5 R6 busy cleared", v, status_exp(0));
    peek(2'd1, v); chk("R7 output byte kept", v, d);
    chk("R11 mode out", mode_out, exp_mode);
  endtask

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    peek(2'd2, v); chk("R1 status", v, 0);
    peek(2'd3, v); chk("R1 command", v, 0);
    peek(2'd0, v); chk("R1 empty read", v, 0);
    chk("R1 tx idle", dev_tx_valid, 0);
    chk("R1 rx ready", dev_rx_ready, 1);
    chk("R1 mode", mode_out, 0);

    wr(2'd3, {6'h2A, 2'b00}); exp_mode = 6'h2A;
    chk("R11 mode stored", mode_out, 6'h2A);
    peek(2'd2, v); chk("R2 no command started", v, 0);
    wr(2'd2, 8'hFF);
    peek(2'd2, v); chk("R2 status write ignored", v, 0);
    wr(2'd0, 8'h55);
    peek(2'd2, v); chk("R2 data-in write ignored", v[1], 0);

    do_cmd(8'hA5, 6'h11, 1, 0, 0);
    do_cmd(8'h3C, 6'h05, 1, 1, 2);
    repeat (4) @(negedge clk);
    peek(2'd2, v); chk("R6 error persists", v[2], 1);
    do_cmd(8'h77, 6'h22, 0, 0, 0);
    peek(2'd2, v); chk("R6 R8 error cleared", v[2], 0);

    peek(2'd0, v); chk("R10 empty read", v, 0);
    @(negedge clk); reg_addr = 0; reg_rd = 1;
    @(negedge clk); reg_rd = 0;
    peek(2'd2, v); chk("R10 empty pop no effect", v, status_exp(0));
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      dev_rx_valid = 1; dev_rx_data = 8'h10 + 8'(i);
      #1 chk("R9 ready vs fill", dev_rx_ready, q.size() < 8);
      if (q.size() < 8) q.push_back(dev_rx_data);
    end
    @(negedge clk); dev_rx_valid = 0;
    peek(2'd2, v); chk("R9 full flag", v, status_exp(0));
    while (q.size() > 0) begin
      reg_addr = 0; reg_rd = 1; #1;
      chk("R10 order", reg_rdata, q[0]);
      void'(q.pop_front());
      @(negedge clk); reg_rd = 0;
    end
    peek(2'd2, v); chk("R10 drained", v[1], 0);

    for (int n = 0; n < 400; n++) begin
      logic rv, rr;
      @(negedge clk);
      rv = $urandom_range(0, 2) != 0; rr = $urandom_range(0, 2) == 0;
      dev_rx_valid = rv; dev_rx_data = 8'($urandom);
      reg_addr = 0; reg_rd = rr; #1;
      chk("R9 ready random", dev_rx_ready, q.size() < 8);
      chk("R10 head random", reg_rdata, q.size() ? q[0] : 8'h00);
      reg_addr = 2; #1;
      chk("R10 avail random", reg_rdata[1], q.size() != 0);
      reg_addr = 0;
      if (rr && q.size() > 0) begin
        if (rv && q.size() < 8) q.push_back(dev_rx_data);
        void'(q.pop_front());
      end else if (rv && q.size() < 8) q.push_back(dev_rx_data);
    end
    @(negedge clk); dev_rx_valid = 0; reg_rd = 0;

    for (int n = 0; n < 30; n++)
      do_cmd(8'($urandom), 6'($urandom), $urandom_range(0, 3) != 0,
             $urandom_range(0, 3) == 0, $urandom_range(0, 3));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule